// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

This block divides its clock by ten with a five-flop twisted-ring (Johnson) shift register. Each advancing edge shifts the ring one place toward its top bit and feeds the inverted top bit back into the bottom stage. Starting from all zeros, the ring walks through ten legal patterns, one per decimal digit. The raw ring pattern is brought out so that a neighbouring decoder can turn it into a display digit. A carry output gives a square wave at one tenth of the advancing rate. That wave can clock the next more significant decade of a chain.

A hold input freezes the count. An asynchronous active-high reset returns the ring to digit 0. A synchronous preset writes any 5-bit pattern into the ring, including patterns that are not legal, so that recovery can be exercised.

A legal ring pattern has at most one place where two neighbouring bits differ. When the pattern has two or more such places, the feedback is forced to 0. Shifting zeros in this way drains any illegal pattern into the ten-state loop.

Top module: `jdecade_counter`

## Requirements
- R1: A high `rst` clears `ring` to 00000 at once, without waiting for a clock edge, and `carry_out` then reads 1. While `rst` is high it overrides `hold` and `preset_en`.
- R2: With `rst` low, `preset_en` low, `hold` low and a legal ring, each rising `clk` edge moves `ring` (bit 4 written first) one step along 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000. After 10000 the ring returns to 00000.
- R3: With `hold` high and `preset_en` low, rising clock edges leave `ring` unchanged.
- R4: With `preset_en` high at a rising edge, `ring` takes `preset_val` whatever the level of `hold`.
- R5: `carry_out` is the inverse of `ring[4]`. It is high for digits 0 to 4 and low for digits 5 to 9, so it rises only on the wrap from digit 9 to digit 0 and repeats every ten advancing edges.
- R6: A ring pattern is illegal when two or more of its four neighbouring bit pairs differ. When an advancing edge meets an illegal pattern, the ring becomes {ring[3:0], 0}.
- R7: From any of the 32 patterns, at most five advancing edges bring the ring to a legal pattern.
- R8: An advancing edge that starts from a legal pattern always ends on a legal pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; the ring acts on its rising edge |
| rst | input | 1 | Asynchronous active-high clear to digit 0 |
| hold | input | 1 | High: rising edges do not advance the ring |
| preset_en | input | 1 | High: load `preset_val` into the ring at the next rising edge |
| preset_val | input | 5 | Pattern to be loaded |
| carry_out | output | 1 | Divide-by-ten square wave for the next decade |
| ring | output | 5 | Raw Johnson ring pattern for a downstream decoder |

## Verification
A ring stuck in an illegal pattern shows at the `ring` port on the first advancing edge after it appears. Because the shift is visible one place per edge, a bad feedback value can be seen at `ring[0]` in the very next cycle. A wrong feedback rule also shifts the rising edges of `carry_out` away from the ten-edge spacing within one decade. The bench starts from each of the 32 possible patterns in turn and compares the ring against an independent sequence table after every edge, so a fault in recovery or in the legal loop shows within five edges.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

    // Number of flops in the twisted ring; the divide ratio follows from it
    parameter int JDC_STAGES = 5;
    localparam int JDC_MODULUS = 2 * JDC_STAGES;
    localparam int JDC_EDGES   = JDC_STAGES - 1;

    typedef logic [JDC_STAGES-1:0] jdc_ring_t;

    typedef struct packed {
        jdc_ring_t ring;
    } jdc_regs_t;

endpackage

// File: rtl/jdc_legal.sv
// Flags a ring pattern as legal when at most one neighbouring bit pair differs
module jdc_legal #(
    parameter int W = 5
) (
    input  logic [W-1:0] ring_i,
    output logic         legal_o
);
    localparam int NE = W - 1;
    localparam int CW = $clog2(W) + 1;

    logic [NE-1:0] boundary;

    generate
        for (genvar i = 0; i < NE; i++) begin : g_bnd
            assign boundary[i] = ring_i[i] ^ ring_i[i+1];
        end
    endgenerate

    logic [CW-1:0] n_bnd;

    always_comb begin
        n_bnd = '0;
        for (int i = 0; i < NE; i++) begin
            n_bnd = n_bnd + CW'(boundary[i]);
        end
        legal_o = (n_bnd <= CW'(1));
    end

endmodule

// File: rtl/jdc_ring_next.sv
// Shift step with antilock feedback: an illegal pattern shifts in zeros
module jdc_ring_next #(
    parameter int W = 5
) (
    input  logic [W-1:0] ring_i,
    input  logic         legal_i,
    output logic [W-1:0] next_o
);
    logic feed;

    always_comb begin
        feed   = legal_i ? ~ring_i[W-1] : 1'b0;
        next_o = {ring_i[W-2:0], feed};
    end

endmodule

// File: rtl/jdecade_counter.sv
module jdecade_counter
    import jdc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold,
    input  logic                  preset_en,
    input  logic [JDC_STAGES-1:0] preset_val,
    output logic                  carry_out,
    output logic [JDC_STAGES-1:0] ring
);
    jdc_regs_t regs_d;
    jdc_regs_t regs_q;

    logic      is_legal;
    jdc_ring_t stepped;

    jdc_legal #(.W(JDC_STAGES)) u_legal (
        .ring_i  (regs_q.ring),
        .legal_o (is_legal)
    );

    jdc_ring_next #(.W(JDC_STAGES)) u_next (
        .ring_i  (regs_q.ring),
        .legal_i (is_legal),
        .next_o  (stepped)
    );

    always_comb begin
        regs_d = regs_q;
        if (preset_en) begin
            regs_d.ring = preset_val;
        end else if (!hold) begin
            regs_d.ring = stepped;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ring      = regs_q.ring;
    assign carry_out = ~regs_q.ring[JDC_STAGES-1];

endmodule

// File: rtl/jdecade_counter_chk.sv
module jdecade_counter_chk #(
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         hold,
    input logic         preset_en,
    input logic [W-1:0] preset_val,
    input logic         carry_out,
    input logic [W-1:0] ring
);
    logic ok_now;
    assign ok_now = ($countones(ring[W-2:0] ^ ring[W-1:1]) <= 1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |-> (ring == '0)); // R1

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (hold && !preset_en) |=> $stable(ring)); // R3

    AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (rst)
        preset_en |=> (ring == $past(preset_val))); // R4

    AST_CARRY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(carry_out) && $past(ok_now) && !$past(preset_en)) |-> (ring == '0)); // R5

    AST_DRAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!hold && !preset_en && !ok_now) |=> (ring == {$past(ring[W-2:0]), 1'b0})); // R6

    AST_LOOP_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!hold && !preset_en && ok_now) |=> ok_now); // R8

endmodule

bind jdecade_counter jdecade_counter_chk #(.W(jdc_pkg::JDC_STAGES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .preset_en  (preset_en),
    .preset_val (preset_val),
    .carry_out  (carry_out),
    .ring       (ring)
);

// File: tb/jdecade_counter_bench.sv
module jdecade_counter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hold = 1'b1;
    logic       preset_en = 1'b0;
    logic [4:0] preset_val = '0;
    logic       carry_out;
    logic [4:0] ring;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    jdecade_counter u_jdecade_counter (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .preset_en  (preset_en),
        .preset_val (preset_val),
        .carry_out  (carry_out),
        .ring       (ring)
    );

    always #10ns clk = ~clk;

    // Legal sequence taken from the requirements, digit 0 first
    logic [4:0] seq [10] = '{5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111,
                             5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000};

    logic [4:0] exp_ring_q [$];
    logic       exp_co_q   [$];
    string      exp_tag_q  [$];
    logic [4:0] model = '0;

    function automatic int digit_of(input logic [4:0] r);
        for (int i = 0; i < 10; i++) begin
            if (seq[i] == r) return i;
        end
        return -1;
    endfunction

    function automatic logic [4:0] model_next(input logic [4:0] r);
        int d;
        d = digit_of(r);
        if (d >= 0) return seq[(d + 1) % 10];
        return {r[3:0], 1'b0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one edge worth of inputs and push the expected result
    task automatic step(input logic h, input logic pe, input logic [4:0] pv, input string tag);
        @(negedge clk);
        hold = h;
        preset_en = pe;
        preset_val = pv;
        if (pe) model = pv;
        else if (!h) model = model_next(model);
        exp_ring_q.push_back(model);
        exp_co_q.push_back(~model[4]);
        exp_tag_q.push_back(tag);
    endtask

    task automatic park_and_drain();
        @(negedge clk);
        hold = 1'b1;
        preset_en = 1'b0;
        wait (exp_ring_q.size() == 0);
        @(posedge clk);
        #6ns;
    endtask

    // Monitor: compare once per edge, away from the edge
    always begin
        @(posedge clk);
        #5ns;
        if (exp_ring_q.size() > 0) begin
            logic [4:0] er;
            logic       ec;
            string      et;
            er = exp_ring_q.pop_front();
            ec = exp_co_q.pop_front();
            et = exp_tag_q.pop_front();
            check((ring === er) && (carry_out === ec), et, {carry_out, ring}, {ec, er});
        end
    end

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rises;
        int last_rise;
        int gap_bad;
        logic prev_co;

        // R1: reset state
        #25ns;
        check((ring === 5'b00000) && (carry_out === 1'b1), "R1 reset state",
              {carry_out, ring}, 6'b100000);
        @(negedge clk);
        rst = 1'b0;
        model = '0;

        // R2 R5 R8: free counting over two and a half decades
        for (int k = 0; k < 25; k++) step(1'b0, 1'b0, 5'b0, "R2 R5 R8 count");
        park_and_drain();

        // R3: hold keeps the digit
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 5'b0, "R3 hold");
        park_and_drain();

        // R4: preset while hold is high, then count on
        step(1'b1, 1'b1, 5'b11100, "R4 preset under hold");
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 5'b0, "R2 after preset");
        park_and_drain();

        // R5: carry rises once every ten advancing edges, at the 9-to-0 wrap
        step(1'b1, 1'b1, 5'b00000, "R4 preset zero");
        park_and_drain();
        rises = 0;
        last_rise = -1;
        gap_bad = 0;
        prev_co = carry_out;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            hold = 1'b0;
            @(posedge clk);
            #5ns;
            if (carry_out && !prev_co) begin
                if (ring !== 5'b00000) gap_bad++;
                if (last_rise >= 0 && (k - last_rise) != 10) gap_bad++;
                last_rise = k;
                rises++;
            end
            prev_co = carry_out;
        end
        @(negedge clk);
        hold = 1'b1;
        model = ring;
        check((rises == 3) && (gap_bad == 0), "R5 carry period",
              6'(rises), 6'd3);

        // R6 R7: start from all 32 patterns
        for (int p = 0; p < 32; p++) begin
            step(1'b1, 1'b1, 5'(p), "R4 load pattern");
            for (int k = 0; k < 5; k++) begin
                step(1'b0, 1'b0, 5'b0, (digit_of(model) < 0) ? "R6 drain" : "R2 R8 legal step");
            end
            park_and_drain();
            check(digit_of(ring) >= 0, "R7 legal within five edges",
                  {1'b0, ring}, {1'b0, model});
        end

        // R1: asynchronous clear mid-cycle, overriding preset and hold
        step(1'b1, 1'b1, 5'b11110, "R4 preset before reset");
        park_and_drain();
        @(negedge clk);
        hold = 1'b0;
        #3ns;
        rst = 1'b1;
        #1ns;
        check((ring === 5'b00000) && (carry_out === 1'b1), "R1 async clear",
              {carry_out, ring}, 6'b100000);
        preset_en = 1'b1;
        preset_val = 5'b10101;
        @(posedge clk);
        #5ns;
        check(ring === 5'b00000, "R1 overrides preset", {1'b0, ring}, 6'b000000);
        @(negedge clk);
        preset_en = 1'b0;
        hold = 1'b1;
        rst = 1'b0;
        model = '0;
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 5'b0, "R2 after reset");
        park_and_drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule